// File: doc/BRIEF.md
# Registered 4-Bit Lookahead Arithmetic and Logic Unit

This block is a 4-bit arithmetic and logic unit whose inputs all pass through flip-flops before any computation. Each rising clock edge captures two operands, a four-bit function code, a mode bit and a carry input. The outputs are combinational from those registers. With the mode bit high, the unit produces one of sixteen bitwise logic functions, and its internal carries are held off. With the mode bit low, it produces one of sixteen arithmetic functions. These include addition and subtraction, with the carry input added in.

Every internal carry comes from a full sum-of-products lookahead network, so no carry ripples from bit to bit. The unit exports a group generate and a group propagate over its four bit positions. Wider datapaths can therefore be built by feeding several units into an external lookahead stage. A carry output and an all-ones result flag complete the interface. The all-ones flag doubles as an equality test when the unit subtracts with no carry input.

Top module: `alu4_cla`

## Requirements
- R1: The operands, function code, mode and carry input are captured on the rising clock edge. Outputs reflect only the most recently captured values. An asynchronous active-low reset clears all captured values, so result, carry output, group generate, group propagate and all-ones flag read 0 during reset.
- R2: With mode = 1, the result for each function code (written as an unsigned value of bits 3..0) is: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R3: With mode = 1, the carry output is 0 and the carry input has no effect on any output.
- R4: With mode = 0, the result is (X + Y + cin) mod 16. Here X = A | (B & s0) | (~B & s1) and Y = (A & B & s3) | (A & ~B & s2), taken bitwise, where s0..s3 are the function-code bits. Code 9 thus gives A + B + cin, and code 6 gives A - B - 1 + cin.
- R5: With mode = 0, the carry output equals bit 4 of X + Y + cin.
- R6: In both modes, group generate is 1 exactly when X + Y >= 16. Group propagate is 1 exactly when X = 1111. Both are independent of the carry input.
- R7: The all-ones flag is the AND of the four result bits. With mode = 0, code 6 and carry input 0, it is 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function code s3..s0 |
| mode_i | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| cin_i | input | 1 | Carry input (active high) |
| f_o | output | 4 | Result |
| cout_o | output | 1 | Carry output |
| grp_g_o | output | 1 | Group generate for cascading |
| grp_p_o | output | 1 | Group propagate for cascading |
| aeb_o | output | 1 | All-ones result flag (equality when subtracting) |

## Verification
Every output is due one register stage after its stimulus. A value driven on a falling edge appears once the following rising edge has passed and stays unchanged until the next rising edge. Each scenario drives on the falling edge and samples 1 ns after the next rising edge. A dedicated check samples between the drive and that rising edge and expects the previous result, which confirms the inputs are not combinationally visible. A sweep covers all 32 mode/code pairs against every operand pair and both carry inputs. It compares against a model built from integer addition and a table of named logic functions, not from the lookahead equations.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int DATA_W = 4;
    localparam int SEL_W  = 4;

    typedef struct packed {
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [SEL_W-1:0]  fsel;
        logic              logic_mode;
        logic              carry_in;
    } alu_ops_t;

    localparam alu_ops_t OPS_RESET = '0;

endpackage

// File: rtl/alu4_op_reg.sv
module alu4_op_reg
    import alu4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  alu_ops_t ops_i,
    output alu_ops_t ops_o
);

    alu_ops_t ops_d;
    alu_ops_t ops_q;

    always_comb begin
        ops_d = ops_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ops_q <= OPS_RESET;
        end else begin
            ops_q <= ops_d;
        end
    end

    assign ops_o = ops_q;

    // R1: every captured field follows the previous cycle's inputs
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ops_q == $past(ops_i)));

endmodule

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms #(
    parameter int W  = 4,
    parameter int SW = 4
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [SW-1:0] sel_i,
    output logic [W-1:0]  prop_o,
    output logic [W-1:0]  gen_o
);

    // Per-bit OR-type term (propagate) and AND-type term (generate).
    // The generate term always implies the propagate term.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign prop_o[g] = a_i[g] | (b_i[g] & sel_i[0]) | (~b_i[g] & sel_i[1]);
        assign gen_o[g]  = (a_i[g] & b_i[g] & sel_i[3]) | (a_i[g] & ~b_i[g] & sel_i[2]);
    end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);

    // Every carry is a flat sum of products back to the carry input.
    always_comb begin
        logic acc;
        logic prod;
        carry_o[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    prod = prod & prop_i[k];
                end
                acc = acc | prod;
            end
            prod = cin_i;
            for (int k = 0; k <= i; k++) begin
                prod = prod & prop_i[k];
            end
            carry_o[i+1] = acc | prod;
        end
    end

    always_comb begin
        logic gacc;
        logic gprod;
        gacc = 1'b0;
        for (int j = 0; j < W; j++) begin
            gprod = gen_i[j];
            for (int k = j + 1; k < W; k++) begin
                gprod = gprod & prop_i[k];
            end
            gacc = gacc | gprod;
        end
        grp_g_o = gacc;
        grp_p_o = &prop_i;
    end

endmodule

// File: rtl/alu4_cla.sv
module alu4_cla
    import alu4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              mode_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] f_o,
    output logic              cout_o,
    output logic              grp_g_o,
    output logic              grp_p_o,
    output logic              aeb_o
);

    alu_ops_t          ops_in;
    alu_ops_t          ops_q;
    logic [DATA_W-1:0] prop;
    logic [DATA_W-1:0] gen;
    logic [DATA_W:0]   carry;
    logic              cin_eff;
    logic [DATA_W-1:0] sum;

    assign ops_in = '{opa: a_i, opb: b_i, fsel: sel_i,
                      logic_mode: mode_i, carry_in: cin_i};

    alu4_op_reg i_op_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ops_i (ops_in),
        .ops_o (ops_q)
    );

    alu4_bit_terms #(.W(DATA_W), .SW(SEL_W)) i_bit_terms (
        .a_i    (ops_q.opa),
        .b_i    (ops_q.opb),
        .sel_i  (ops_q.fsel),
        .prop_o (prop),
        .gen_o  (gen)
    );

    // Logic mode cuts the carry input out of the lookahead network.
    assign cin_eff = ops_q.carry_in & ~ops_q.logic_mode;

    alu4_lookahead #(.W(DATA_W)) i_lookahead (
        .gen_i   (gen),
        .prop_i  (prop),
        .cin_i   (cin_eff),
        .carry_o (carry),
        .grp_g_o (grp_g_o),
        .grp_p_o (grp_p_o)
    );

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            if (ops_q.logic_mode) begin
                sum[i] = ~(prop[i] ^ gen[i]);
            end else begin
                sum[i] = prop[i] ^ gen[i] ^ carry[i];
            end
        end
    end

    assign f_o    = sum;
    assign aeb_o  = &sum;
    assign cout_o = carry[DATA_W] & ~ops_q.logic_mode;

    // R3: logic mode never reports a carry out
    a_r3_no_carry_logic: assert property (@(posedge clk) disable iff (!rst_n)
        ops_q.logic_mode |-> !cout_o);

    // R2: logic code 6 is exclusive-OR of the captured operands
    a_r2_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (ops_q.logic_mode && ops_q.fsel == 4'd6) |-> (f_o == (ops_q.opa ^ ops_q.opb)));

    // R4 / R5: arithmetic code 9 is a true add with carry out
    a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!ops_q.logic_mode && ops_q.fsel == 4'd9) |->
        ({cout_o, f_o} == ((DATA_W+1)'(ops_q.opa) + (DATA_W+1)'(ops_q.opb)
                           + (DATA_W+1)'(ops_q.carry_in))));

    // R6: a group generate in arithmetic mode always yields a carry out
    a_r6_gen_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!ops_q.logic_mode && grp_g_o) |-> cout_o);

    // R7: subtract with no carry in flags equality
    a_r7_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (!ops_q.logic_mode && ops_q.fsel == 4'd6 && !ops_q.carry_in) |->
        (aeb_o == (ops_q.opa == ops_q.opb)));

endmodule

// File: tb/test_alu4_cla.sv
`timescale 1ns/1ps
module test_alu4_cla;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a = '0, b = '0, sel = '0;
    logic       mode = 1'b0, cin = 1'b0;
    logic [3:0] f;
    logic       cout, gg, gp, aeb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    alu4_cla i_alu4_cla (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sel_i(sel),
        .mode_i(mode), .cin_i(cin), .f_o(f), .cout_o(cout),
        .grp_g_o(gg), .grp_p_o(gp), .aeb_o(aeb)
    );

    typedef struct packed {
        logic [3:0] f;
        logic       cout;
        logic       g;
        logic       p;
        logic       aeb;
    } exp_t;

    function automatic logic [3:0] logic_fn(input logic [3:0] x, input logic [3:0] y,
                                            input logic [3:0] s);
        case (s)
            4'd0:  return ~x;
            4'd1:  return ~(x | y);
            4'd2:  return ~x & y;
            4'd3:  return 4'b0000;
            4'd4:  return ~(x & y);
            4'd5:  return ~y;
            4'd6:  return x ^ y;
            4'd7:  return x & ~y;
            4'd8:  return ~x | y;
            4'd9:  return ~(x ^ y);
            4'd10: return y;
            4'd11: return x & y;
            4'd12: return 4'b1111;
            4'd13: return x | ~y;
            4'd14: return x | y;
            default: return x;
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] x, input logic [3:0] y,
                                   input logic [3:0] s, input logic m, input logic c);
        exp_t e;
        logic [3:0] xx, yy;
        int sum0, sumc;
        xx = x | (y & {4{s[0]}}) | (~y & {4{s[1]}});
        yy = (x & y & {4{s[3]}}) | (x & ~y & {4{s[2]}});
        sum0 = int'(xx) + int'(yy);
        sumc = sum0 + int'(c);
        e.g = (sum0 >= 16);
        e.p = (xx == 4'hF);
        if (m) begin
            e.f = logic_fn(x, y, s);
            e.cout = 1'b0;
        end else begin
            e.f = 4'(sumc);
            e.cout = (sumc >= 16);
        end
        e.aeb = &e.f;
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] x, input logic [3:0] y, input logic [3:0] s,
                         input logic m, input logic c);
        @(negedge clk);
        a = x; b = y; sel = s; mode = m; cin = c;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input logic [3:0] x, input logic [3:0] y, input logic [3:0] s,
                             input logic m, input logic c);
        exp_t e;
        e = model(x, y, s, m, c);
        chk(m ? "R2" : "R4", "result", int'(f), int'(e.f));
        chk(m ? "R3" : "R5", "carry out", int'(cout), int'(e.cout));
        chk("R6", "group generate", int'(gg), int'(e.g));
        chk("R6", "group propagate", int'(gp), int'(e.p));
        chk("R7", "all-ones flag", int'(aeb), int'(e.aeb));
    endtask

    // R1: reset clears the captured inputs
    task automatic t_reset();
        rst_n = 1'b0;
        a = 4'hF; b = 4'h3; sel = 4'd9; mode = 1'b0; cin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset result", int'(f), 0);
        chk("R1", "reset carry", int'(cout), 0);
        chk("R1", "reset generate", int'(gg), 0);
        chk("R1", "reset propagate", int'(gp), 0);
        chk("R1", "reset flag", int'(aeb), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R4 / R5 / R2: named operations with hand-worked values
    task automatic t_named();
        apply(4'd12, 4'd7, 4'd9, 1'b0, 1'b0);
        chk("R4", "12+7 result", int'(f), 3);
        chk("R5", "12+7 carry", int'(cout), 1);
        apply(4'd9, 4'd5, 4'd9, 1'b0, 1'b1);
        chk("R4", "9+5+1 result", int'(f), 15);
        chk("R5", "9+5+1 carry", int'(cout), 0);
        apply(4'd7, 4'd3, 4'd6, 1'b0, 1'b1);
        chk("R4", "7-3 result", int'(f), 4);
        apply(4'd12, 4'd10, 4'd6, 1'b1, 1'b0);
        chk("R2", "xor", int'(f), 6);
        apply(4'd12, 4'd10, 4'd11, 1'b1, 1'b0);
        chk("R2", "and", int'(f), 8);
        apply(4'd12, 4'd10, 4'd14, 1'b1, 1'b0);
        chk("R2", "or", int'(f), 14);
    endtask

    // R3: carry input ignored in logic mode
    task automatic t_logic_cin();
        for (int s = 0; s < 16; s++) begin
            apply(4'd5, 4'd9, 4'(s), 1'b1, 1'b1);
            chk("R3", "result with cin=1", int'(f), int'(logic_fn(4'd5, 4'd9, 4'(s))));
            chk("R3", "carry with cin=1", int'(cout), 0);
        end
        apply(4'hF, 4'hF, 4'd9, 1'b1, 1'b1);
        chk("R3", "carry forced low", int'(cout), 0);
    endtask

    // R7: equality through subtraction
    task automatic t_equal();
        apply(4'd10, 4'd10, 4'd6, 1'b0, 1'b0);
        chk("R7", "equal operands", int'(aeb), 1);
        apply(4'd10, 4'd11, 4'd6, 1'b0, 1'b0);
        chk("R7", "unequal operands", int'(aeb), 0);
    endtask

    // R1: no combinational path from the inputs
    task automatic t_latency();
        apply(4'd1, 4'd2, 4'd9, 1'b0, 1'b0);
        chk("R1", "first result", int'(f), 3);
        @(negedge clk);
        a = 4'd6; b = 4'd6;
        #1;
        chk("R1", "held before edge", int'(f), 3);
        @(posedge clk);
        #1;
        chk("R1", "updated after edge", int'(f), 12);
    endtask

    // R2, R4, R5, R6, R7: full sweep
    task automatic t_sweep();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int x = 0; x < 16; x++) begin
                    for (int y = 0; y < 16; y++) begin
                        for (int c = 0; c < 2; c++) begin
                            apply(4'(x), 4'(y), 4'(s), 1'(m), 1'(c));
                            check_all(4'(x), 4'(y), 4'(s), 1'(m), 1'(c));
                        end
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_named();
        t_logic_cin();
        t_equal();
        t_latency();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule